// File: doc/BRIEF.md
# Byte-Synchronous Receive Hunt Detector

This block searches a serial receive bit stream for programmed sync characters, as used by byte-oriented synchronous links. It holds a one-character or two-character sync pattern, supplied on two 8-bit inputs. It shifts one received bit per enabled cycle into a hunt window and compares the window on every bit time. Because the comparison is not limited to byte boundaries, the character alignment is recovered from the pattern itself. In single-character mode the newest 8 bits must equal the second sync value. In two-character mode the 8 bits before them must also equal the first sync value, in the same cycle.

When the pattern matches, the block locks. From that point on, received bits skip the hunt window and go straight to a byte assembler. Bytes are counted from the bit that follows the lock bit and are presented on a valid/ready stream output. The serial line cannot be stalled. For that reason the back-pressure rule is: a byte that has not been taken stays stable, but the next completed byte replaces it. A second output carries each locked bit again, 8 locked bits later, for a downstream CRC checker. This delay gives control software one character time to decide whether each character goes into the CRC. A one-cycle `enter_hunt` pulse drops the lock and starts the search again.

Top module: `sync_hunt_rx`

## Requirements
- R1: After reset the block is in hunt: `locked`, `sync_detected`, `out_valid` and `crc_valid` are all 0, and no byte or CRC bit is produced while in hunt.
- R2: In single-character mode (`bisync_mode`=0), lock occurs on the enabled bit where the last 8 received bits equal `sync_char2`. The bits are taken LSB-first: the oldest of the 8 is bit 0 and the newest is bit 7. Lock can occur only once at least 8 bits have been received since the hunt started.
- R3: In two-character mode (`bisync_mode`=1), lock occurs on the enabled bit where two conditions hold together: the newest 8 bits equal `sync_char2`, and the 8 bits just before them equal `sync_char1`, both LSB-first. Lock can occur only once at least 16 bits have been received since the hunt started.
- R4: `sync_detected` is a one-cycle pulse, registered in the same clock edge on which `locked` rises. It does not pulse again until a new hunt has started.
- R5: While locked, every 8 enabled bits after the lock bit form one byte, with the first received bit in bit 0. That byte appears on `out_data` with `out_valid`=1 in the cycle after the edge that took its 8th bit.
- R6: While `out_valid`=1 and `out_ready`=0, `out_data` stays stable until another byte completes, and that byte then replaces it. A handshake (`out_valid` and `out_ready` both 1) clears `out_valid` unless a new byte completes on the same edge.
- R7: While locked, from the 9th locked bit on, each enabled bit raises `crc_valid` for one cycle. `crc_bit` then carries the locked bit received 8 enabled bits earlier.
- R8: An `enter_hunt` pulse takes priority over everything else. It clears the lock, the pending byte, the bit count, the CRC delay and the hunt window, and the bit offered in that cycle is dropped.
- R9: A cycle with `rx_bit_en`=0 and no `enter_hunt` changes neither the lock nor the partial byte, and produces no `sync_detected` or `crc_valid` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_bit_en | input | 1 | One received bit is offered this cycle |
| rx_bit | input | 1 | Received serial bit |
| bisync_mode | input | 1 | 0: one sync character, 1: two sync characters |
| sync_char1 | input | 8 | First (earlier) sync character, two-character mode only |
| sync_char2 | input | 8 | Sync character (the later one in two-character mode) |
| enter_hunt | input | 1 | Synchronous pulse that restarts the hunt |
| locked | output | 1 | Character synchronization established |
| sync_detected | output | 1 | One-cycle pulse when lock is achieved |
| out_data | output | 8 | Assembled data byte |
| out_valid | output | 1 | `out_data` holds a byte not yet taken |
| out_ready | input | 1 | Consumer accepts the byte this cycle |
| crc_bit | output | 1 | Locked bit delayed by one character |
| crc_valid | output | 1 | `crc_bit` is valid this cycle |

## Verification
A hunt window that is wrong by one bit position moves the lock edge by a bit time. That shows up on `sync_detected` in the cycle the pattern completes, and the bytes after it come out misaligned. A bit counter that does not restart at lock corrupts the first byte, which is visible 8 enabled bits after `sync_detected`. A delay line of the wrong length gives a wrong `crc_bit` on the first `crc_valid` pulse. The bench compares `locked`, `sync_detected`, the stream outputs and the CRC tap against a bit-level model on every cycle, so any of these faults is caught within one character time of the fault.

// File: rtl/sync_hunt_pkg.sv
package sync_hunt_pkg;
  typedef enum logic {
    ST_HUNT   = 1'b0,
    ST_LOCKED = 1'b1
  } hunt_state_e;

  // Next value of an LSB-first shift register: the new bit enters at the top.
  function automatic logic [7:0] shift_in8(input logic [7:0] cur, input logic b);
    return {b, cur[7:1]};
  endfunction
endpackage

// File: rtl/sync_hunt_window.sv
module sync_hunt_window #(
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              shift_en,
  input  logic              bit_in,
  input  logic              bisync,
  input  logic [CHAR_W-1:0] sync1,
  input  logic [CHAR_W-1:0] sync2,
  output logic              match
);
  localparam int FILL_MAX = 2 * CHAR_W;
  localparam int FW       = $clog2(FILL_MAX + 1);

  logic [CHAR_W-1:0] hunt_q, prev_q, hunt_d, prev_d;
  logic [FW-1:0]     fill_q, fill_d;
  logic              one_ok, two_ok;

  always_comb begin
    hunt_d = {bit_in, hunt_q[CHAR_W-1:1]};
    prev_d = {hunt_q[0], prev_q[CHAR_W-1:1]};
    fill_d = (fill_q == FW'(FILL_MAX)) ? fill_q : fill_q + FW'(1);
    one_ok = (fill_d >= FW'(CHAR_W)) && (hunt_d == sync2);
    two_ok = (fill_d == FW'(FILL_MAX)) && (hunt_d == sync2) && (prev_d == sync1);
    match  = shift_en && (bisync ? two_ok : one_ok);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hunt_q <= '0;
      prev_q <= '0;
      fill_q <= '0;
    end else if (clear) begin
      hunt_q <= '0;
      prev_q <= '0;
      fill_q <= '0;
    end else if (shift_en) begin
      hunt_q <= hunt_d;
      prev_q <= prev_d;
      fill_q <= fill_d;
    end
  end
endmodule

// File: rtl/sync_byte_assembler.sv
module sync_byte_assembler #(
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              bit_en,
  input  logic              bit_in,
  input  logic              out_ready,
  output logic [CHAR_W-1:0] out_data,
  output logic              out_valid
);
  localparam int CW = (CHAR_W > 1) ? $clog2(CHAR_W) : 1;

  logic [CW-1:0]     cnt_q;
  logic [CHAR_W-1:0] acc_q, acc_d;
  logic              done;

  always_comb begin
    acc_d = {bit_in, acc_q[CHAR_W-1:1]};
    done  = bit_en && (cnt_q == CW'(CHAR_W - 1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      acc_q     <= '0;
      out_data  <= '0;
      out_valid <= 1'b0;
    end else if (clear) begin
      cnt_q     <= '0;
      acc_q     <= '0;
      out_valid <= 1'b0;
    end else begin
      if (bit_en) begin
        acc_q <= acc_d;
        cnt_q <= done ? '0 : cnt_q + CW'(1);
      end
      if (done) begin
        out_data  <= acc_d;
        out_valid <= 1'b1;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/sync_crc_delay.sv
module sync_crc_delay #(
  parameter int DELAY = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic bit_en,
  input  logic bit_in,
  output logic crc_bit,
  output logic crc_valid
);
  localparam int SW = $clog2(DELAY + 1);

  logic [DELAY-1:0] line_q;
  logic [SW-1:0]    seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q    <= '0;
      seen_q    <= '0;
      crc_bit   <= 1'b0;
      crc_valid <= 1'b0;
    end else if (clear) begin
      line_q    <= '0;
      seen_q    <= '0;
      crc_valid <= 1'b0;
    end else begin
      crc_valid <= 1'b0;
      if (bit_en) begin
        line_q  <= {bit_in, line_q[DELAY-1:1]};
        crc_bit <= line_q[0];
        if (seen_q == SW'(DELAY)) crc_valid <= 1'b1;
        else                      seen_q    <= seen_q + SW'(1);
      end
    end
  end
endmodule

// File: rtl/sync_hunt_rx.sv
module sync_hunt_rx #(
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_bit_en,
  input  logic              rx_bit,
  input  logic              bisync_mode,
  input  logic [CHAR_W-1:0] sync_char1,
  input  logic [CHAR_W-1:0] sync_char2,
  input  logic              enter_hunt,
  output logic              locked,
  output logic              sync_detected,
  output logic [CHAR_W-1:0] out_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              crc_bit,
  output logic              crc_valid
);
  import sync_hunt_pkg::*;

  localparam int CRC_DELAY = CHAR_W;

  hunt_state_e state_q;
  logic        win_shift, win_match, data_en;

  assign win_shift = rx_bit_en && !enter_hunt && (state_q == ST_HUNT);
  assign data_en   = rx_bit_en && !enter_hunt && (state_q == ST_LOCKED);
  assign locked    = (state_q == ST_LOCKED);

  sync_hunt_window #(.CHAR_W(CHAR_W)) u_window (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (enter_hunt),
    .shift_en (win_shift),
    .bit_in   (rx_bit),
    .bisync   (bisync_mode),
    .sync1    (sync_char1),
    .sync2    (sync_char2),
    .match    (win_match)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q       <= ST_HUNT;
      sync_detected <= 1'b0;
    end else begin
      sync_detected <= 1'b0;
      if (enter_hunt) begin
        state_q <= ST_HUNT;
      end else if (win_match) begin
        state_q       <= ST_LOCKED;
        sync_detected <= 1'b1;
      end
    end
  end

  sync_byte_assembler #(.CHAR_W(CHAR_W)) u_bytes (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (enter_hunt),
    .bit_en    (data_en),
    .bit_in    (rx_bit),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_valid (out_valid)
  );

  sync_crc_delay #(.DELAY(CRC_DELAY)) u_crc_tap (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (enter_hunt),
    .bit_en    (data_en),
    .bit_in    (rx_bit),
    .crc_bit   (crc_bit),
    .crc_valid (crc_valid)
  );
endmodule

// File: rtl/sync_hunt_rx_checks.sv
module sync_hunt_rx_checks #(
  parameter int CHAR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rx_bit_en,
  input logic              enter_hunt,
  input logic              locked,
  input logic              sync_detected,
  input logic [CHAR_W-1:0] out_data,
  input logic              out_valid,
  input logic              out_ready,
  input logic              crc_valid
);
  assert_no_data_in_hunt_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !locked |-> (!out_valid && !crc_valid));

  assert_lock_on_bit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sync_detected |-> $past(rx_bit_en));

  assert_pulse_with_lock_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sync_detected |-> (locked && !$past(locked)));

  assert_single_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sync_detected |=> !sync_detected);

  assert_no_byte_at_lock_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sync_detected |-> (!out_valid && !crc_valid));

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !rx_bit_en && !enter_hunt) |=> (out_valid && $stable(out_data)));

  assert_hunt_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    enter_hunt |=> (!locked && !out_valid && !crc_valid));

  assert_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_bit_en && !enter_hunt) |=> ($stable(locked) && !sync_detected && !crc_valid));
endmodule

bind sync_hunt_rx sync_hunt_rx_checks #(.CHAR_W(CHAR_W)) u_checks (
  .clk           (clk),
  .rst_n         (rst_n),
  .rx_bit_en     (rx_bit_en),
  .enter_hunt    (enter_hunt),
  .locked        (locked),
  .sync_detected (sync_detected),
  .out_data      (out_data),
  .out_valid     (out_valid),
  .out_ready     (out_ready),
  .crc_valid     (crc_valid)
);

// File: tb/sync_hunt_rx_bench.sv
module sync_hunt_rx_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_bit_en = 1'b0, rx_bit = 1'b0, bisync_mode = 1'b0;
  logic [7:0] sync_char1 = 8'h32, sync_char2 = 8'h16;
  logic       enter_hunt = 1'b0, out_ready = 1'b0;
  logic       locked, sync_detected, out_valid, crc_bit, crc_valid;
  logic [7:0] out_data;

  int checks = 0, errors = 0;
  bit finished = 1'b0;

  // bit-level reference state
  bit        m_locked, m_sd, m_valid, m_crcv, m_crcb;
  bit [15:0] m_hist;
  int        m_fill, m_cnt, m_lkn;
  bit [7:0]  m_acc, m_data;
  bit [8:0]  m_lk;

  sync_hunt_rx u_sync_hunt_rx (
    .clk(clk), .rst_n(rst_n), .rx_bit_en(rx_bit_en), .rx_bit(rx_bit),
    .bisync_mode(bisync_mode), .sync_char1(sync_char1), .sync_char2(sync_char2),
    .enter_hunt(enter_hunt), .locked(locked), .sync_detected(sync_detected),
    .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready),
    .crc_bit(crc_bit), .crc_valid(crc_valid)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    m_locked = 0; m_sd = 0; m_valid = 0; m_crcv = 0; m_crcb = 0;
    m_hist = '0; m_fill = 0; m_cnt = 0; m_lkn = 0; m_acc = '0; m_lk = '0;
  endtask

  function automatic bit hunt_match(input bit bis);
    if (bis) return (m_fill >= 16) && (m_hist[15:8] == sync_char2) && (m_hist[7:0] == sync_char1);
    return (m_fill >= 8) && (m_hist[15:8] == sync_char2);
  endfunction

  task automatic model_edge(input bit en, input bit b, input bit rdy, input bit hunt);
    m_sd = 0; m_crcv = 0;
    if (hunt) begin
      model_reset();
    end else begin
      if (m_valid && rdy) m_valid = 0;
      if (en && !m_locked) begin
        m_hist = {b, m_hist[15:1]};
        if (m_fill < 16) m_fill++;
        if (hunt_match(bisync_mode)) begin
          m_locked = 1; m_sd = 1; m_cnt = 0; m_lkn = 0;
        end
      end else if (en) begin
        m_acc = {b, m_acc[7:1]};
        m_cnt++;
        if (m_cnt == 8) begin m_data = m_acc; m_valid = 1; m_cnt = 0; end
        m_lk = {m_lk[7:0], b};
        if (m_lkn < 9) m_lkn++;
        if (m_lkn >= 9) begin m_crcv = 1; m_crcb = m_lk[8]; end
      end
    end
  endtask

  task automatic step(input bit en, input bit b, input bit rdy, input bit hunt);
    rx_bit_en = en; rx_bit = b; out_ready = rdy; enter_hunt = hunt;
    @(posedge clk);
    model_edge(en, b, rdy, hunt);
    #(CLK_PERIOD/4);
    chk(locked == m_locked, bisync_mode ? "R3" : "R2", "locked", locked, m_locked);
    chk(sync_detected == m_sd, "R4", "sync_detected", sync_detected, m_sd);
    chk(out_valid == m_valid, "R5", "out_valid", out_valid, m_valid);
    if (m_valid) chk(out_data == m_data, "R5", "out_data", out_data, m_data);
    chk(crc_valid == m_crcv, "R7", "crc_valid", crc_valid, m_crcv);
    if (m_crcv) chk(crc_bit == m_crcb, "R7", "crc_bit", crc_bit, m_crcb);
  endtask

  task automatic send_byte(input bit [7:0] v, input bit rdy);
    for (int i = 0; i < 8; i++) step(1'b1, v[i], rdy, 1'b0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    bit [7:0] held;
    void'($urandom(32'h5EED_1234));
    model_reset();
    #(CLK_PERIOD * 3);
    @(negedge clk);
    rst_n = 1'b1;
    #(CLK_PERIOD/4);
    // R1: reset state
    chk(!locked && !sync_detected && !out_valid && !crc_valid, "R1", "reset outputs",
        {locked, sync_detected, out_valid, crc_valid}, 0);

    // R2: zero sync char cannot lock before 8 bits are in
    sync_char2 = 8'h00; bisync_mode = 1'b0;
    for (int i = 0; i < 7; i++) step(1'b1, 1'b0, 1'b1, 1'b0);
    chk(!locked, "R2", "no lock before 8 bits", locked, 0);
    step(1'b1, 1'b0, 1'b1, 1'b0);
    chk(locked && sync_detected, "R2", "lock on 8th zero", {locked, sync_detected}, 3);
    step(1'b0, 1'b0, 1'b1, 1'b1);
    chk(!locked && !out_valid, "R8", "hunt clears lock", {locked, out_valid}, 0);

    // R2/R5/R7: single-character lock, bytes and CRC tap
    sync_char2 = 8'h16;
    send_byte(8'hA5, 1'b1); send_byte(8'h16, 1'b1);
    chk(locked, "R2", "locked after sync2", locked, 1);
    send_byte(8'h3C, 1'b1);
    chk(out_valid && out_data == 8'h3C, "R5", "first byte", out_data, 8'h3C);
    send_byte(8'hE1, 1'b1); send_byte(8'h07, 1'b1);

    // R6: back-pressure hold and overwrite
    send_byte(8'h5A, 1'b0);
    for (int i = 0; i < 5; i++) step(1'b0, 1'b1, 1'b0, 1'b0);
    chk(out_valid && out_data == 8'h5A, "R6", "held byte", out_data, 8'h5A);
    chk(locked, "R9", "idle keeps lock", locked, 1);
    send_byte(8'hC3, 1'b0);
    chk(out_data == 8'hC3, "R6", "overwrite", out_data, 8'hC3);
    step(1'b0, 1'b0, 1'b1, 1'b0);
    chk(!out_valid, "R6", "handshake clears", out_valid, 0);

    // R8: hunt with a bit offered in the same cycle drops it
    step(1'b1, 1'b1, 1'b1, 1'b1);
    chk(!locked && !crc_valid, "R8", "hunt priority", {locked, crc_valid}, 0);

    // R3: two-character mode: second char alone must not lock
    bisync_mode = 1'b1;
    send_byte(8'h99, 1'b1); send_byte(8'h16, 1'b1);
    chk(!locked, "R3", "sync2 alone", locked, 0);
    send_byte(8'h32, 1'b1); send_byte(8'h16, 1'b1);
    chk(locked, "R3", "sync1+sync2", locked, 1);
    send_byte(8'h81, 1'b1);
    chk(out_data == 8'h81, "R5", "bisync byte", out_data, 8'h81);
    // R9: gaps in enables inside a byte
    for (int i = 0; i < 8; i++) begin
      step(1'b0, 1'b0, 1'b1, 1'b0);
      step(1'b1, i[0], 1'b1, 1'b0);
    end
    chk(out_valid && out_data == 8'hAA, "R9", "byte across gaps", out_data, 8'hAA);

    // constrained random
    held = 8'h00;
    for (int n = 0; n < 6000; n++) begin
      int r = $urandom % 100;
      if (r < 2) begin
        bisync_mode = 1'($urandom % 2);
        step(1'($urandom % 2), 1'($urandom % 2), 1'($urandom % 2), 1'b1);
      end else if (r < 6) begin
        if (bisync_mode) send_byte(sync_char1, 1'b1);
        send_byte(sync_char2, 1'b1);
      end else begin
        step(($urandom % 4) != 0, 1'($urandom % 2), ($urandom % 3) != 0, 1'b0);
      end
    end

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule